// File: doc/BRIEF.md
# Four-Beat Burst Address Generator with Byte-Write Decode

This block produces the word address presented to a synchronous SRAM array during four-beat bursts. A burst opens when either of two address strobes is sampled high: the processor strobe or the controller strobe. The rising clock edge that sees the strobe captures the whole external address. The upper address bits stay frozen for the rest of the burst. Each later edge that sees the advance input high moves the low two bits one beat forward. A static order input chooses how the beats run. In interleaved order the low bits are the starting bits XOR the beat count. In linear order they are the starting bits plus the beat count, wrapping within a block of four.

The same unit registers the write controls for the array, which times its own write pulse. Each byte lane has its own select. A lane is written when the common byte-write enable and that lane's select are both high. A global write enable writes every lane, whatever the selects and the byte-write enable say. The storage array sits outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (active-low `rstN`) is held, `curAddr` and `byteWrite` read all zeros.
- R2: When `procStrobe` or `ctrlStrobe` is high at a rising edge, `curAddr` equals the sampled `extAddr` after that edge, and the beat count restarts at zero.
- R3: When both strobes are high in the same cycle, the cycle starts a new burst, and a simultaneous `advance` has no effect on `curAddr`.
- R4: With no strobe, an edge that samples `advance` high moves the beat count up by one. An edge that samples `advance` low leaves `curAddr` unchanged.
- R5: With `linearOrder` = 0, the low two bits of `curAddr` equal the starting low bits XOR the beat count.
- R6: With `linearOrder` = 1, the low two bits of `curAddr` equal (starting low bits + beat count) mod 4.
- R7: Advancing past the fourth beat wraps the sequence inside the same four-word block, and `curAddr[17:2]` keeps the burst's start value.
- R8: After each edge, `byteWrite[i]` equals `byteWrEn` AND `byteSel[i]` as sampled at that edge. Bit 0 is the lower 9-bit byte and bit 1 is the upper byte.
- R9: After an edge that samples `globalWr` high, `byteWrite` is all ones, whatever `byteWrEn` and `byteSel` are.
- R10: The write controls (`byteWrEn`, `byteSel`, `globalWr`) have no effect on `curAddr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| procStrobe | input | 1 | Processor address strobe; starts a burst and wins over the controller strobe |
| ctrlStrobe | input | 1 | Controller address strobe; starts a burst |
| advance | input | 1 | Steps the burst one beat forward |
| linearOrder | input | 1 | 1 selects linear order, 0 selects interleaved order; held static |
| extAddr | input | 18 | External address captured at a burst start |
| byteWrEn | input | 1 | Common byte-write enable |
| byteSel | input | 2 | Per-lane byte selects |
| globalWr | input | 1 | Writes all lanes |
| curAddr | output | 18 | Current internal address |
| byteWrite | output | 2 | Registered per-lane write enables |

## Verification
Every control takes effect at the first rising edge that samples it. The new address and the new write enables are therefore due one clock after the stimulus. The order input is the one exception: it acts combinationally on the low address bits. The bench drives its inputs at a falling edge and queues the expected result for the rising edge that follows. It compares that result a quarter period after the rising edge, so each expectation is matched to exactly the edge that produces it. The expected address comes from a separate model of start bits, beat count and order, and the expected lane enables from the R8 and R9 rules.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  // Strobes passed from the burst control to the address datapath.
  typedef struct packed {
    logic loadStart;  // capture external address, restart beat count
    logic stepBeat;   // move one beat forward
  } burstStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
`timescale 1ns/1ps
module burst_ctrl
  import burst_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          procStrobe,
  input  logic          ctrlStrobe,
  input  logic          advance,
  output burstStrobes_t strobes
);
  // Priority: processor strobe, then controller strobe, then advance.
  always_comb begin
    strobes = '0;
    if (procStrobe) begin
      strobes.loadStart = 1'b1;
    end else if (ctrlStrobe) begin
      strobes.loadStart = 1'b1;
    end else if (advance) begin
      strobes.stepBeat = 1'b1;
    end
  end

  // A start and a step never travel together (R3).
  assert_start_excludes_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadStart && strobes.stepBeat));
endmodule

// File: rtl/burst_datapath.sv
`timescale 1ns/1ps
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobes_t     strobes,
  input  logic              linearOrder,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int HIGH_W = ADDR_W - BURST_BITS;
  localparam logic [BURST_BITS-1:0] ONE_BEAT = BURST_BITS'(1);

  logic [HIGH_W-1:0]     highReg;
  logic [BURST_BITS-1:0] startLow;
  logic [BURST_BITS-1:0] beatReg;
  logic [BURST_BITS-1:0] lowAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highReg  <= '0;
      startLow <= '0;
      beatReg  <= '0;
    end else if (strobes.loadStart) begin
      highReg  <= extAddr[ADDR_W-1:BURST_BITS];
      startLow <= extAddr[BURST_BITS-1:0];
      beatReg  <= '0;
    end else if (strobes.stepBeat) begin
      beatReg  <= beatReg + ONE_BEAT;  // wraps inside the block
    end
  end

  // Interleaved order: XOR with the beat count; linear order: wrapping add.
  always_comb begin
    if (linearOrder) lowAddr = startLow + beatReg;
    else             lowAddr = startLow ^ beatReg;
  end

  assign curAddr = {highReg, lowAddr};

  assert_load_address_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadStart |=> (curAddr == $past(extAddr)) && (beatReg == '0));

  assert_step_beat_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stepBeat |=> beatReg == BURST_BITS'($past(beatReg) + ONE_BEAT));

  assert_hold_beat_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadStart && !strobes.stepBeat |=> $stable(beatReg) && $stable(startLow));

  assert_block_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadStart |=> $stable(curAddr[ADDR_W-1:BURST_BITS]));
endmodule

// File: rtl/byte_write_decode.sv
`timescale 1ns/1ps
module byte_write_decode #(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 byteWrEn,
  input  logic [NUM_BYTES-1:0] byteSel,
  input  logic                 globalWr,
  output logic [NUM_BYTES-1:0] byteWrite
);
  logic [NUM_BYTES-1:0] nextWrite;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign nextWrite[g] = globalWr | (byteWrEn & byteSel[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteWrite <= '0;
    else       byteWrite <= nextWrite;
  end

  assert_global_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    globalWr |=> &byteWrite);

  assert_no_enable_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !globalWr && !byteWrEn |=> byteWrite == '0);

  assert_lane_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    !globalWr && byteWrEn |=> $countones(byteWrite) == $countones($past(byteSel)));
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2,
  parameter int NUM_BYTES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 procStrobe,
  input  logic                 ctrlStrobe,
  input  logic                 advance,
  input  logic                 linearOrder,
  input  logic [ADDR_W-1:0]    extAddr,
  input  logic                 byteWrEn,
  input  logic [NUM_BYTES-1:0] byteSel,
  input  logic                 globalWr,
  output logic [ADDR_W-1:0]    curAddr,
  output logic [NUM_BYTES-1:0] byteWrite
);
  burstStrobes_t strobes;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .strobes    (strobes)
  );

  burst_datapath #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .linearOrder (linearOrder),
    .extAddr     (extAddr),
    .curAddr     (curAddr)
  );

  byte_write_decode #(
    .NUM_BYTES (NUM_BYTES)
  ) u_wrdec (
    .clk       (clk),
    .rstN      (rstN),
    .byteWrEn  (byteWrEn),
    .byteSel   (byteSel),
    .globalWr  (globalWr),
    .byteWrite (byteWrite)
  );

  // Either strobe opens a burst at the sampled address (R2, R3).
  assert_strobe_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe || ctrlStrobe) |=> curAddr == $past(extAddr));
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rstN;
  logic          procStrobe, ctrlStrobe, advance, linearOrder;
  logic [AW-1:0] extAddr;
  logic          byteWrEn, globalWr;
  logic [1:0]    byteSel;
  logic [AW-1:0] curAddr;
  logic [1:0]    byteWrite;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    wr;
    string         tag;
  } expItem_t;
  expItem_t expQ[$];

  // Reference model state
  logic [AW-3:0] mHigh = '0;
  logic [1:0]    mStart = '0;
  logic [1:0]    mBeat = '0;

  always #10 clk = ~clk;  // 50 MHz

  burst_addr_gen uut (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .advance(advance), .linearOrder(linearOrder), .extAddr(extAddr),
    .byteWrEn(byteWrEn), .byteSel(byteSel), .globalWr(globalWr),
    .curAddr(curAddr), .byteWrite(byteWrite)
  );

  task automatic drive(input logic p, input logic c, input logic a, input logic lin,
                       input logic [AW-1:0] ea, input logic bwe, input logic [1:0] sel,
                       input logic gw, input string tag);
    expItem_t it;
    logic [1:0] low;
    @(negedge clk);
    procStrobe = p; ctrlStrobe = c; advance = a; linearOrder = lin;
    extAddr = ea; byteWrEn = bwe; byteSel = sel; globalWr = gw;
    if (p || c) begin
      mHigh = ea[AW-1:2]; mStart = ea[1:0]; mBeat = 2'd0;
    end else if (a) begin
      mBeat = mBeat + 2'd1;
    end
    low = lin ? (mStart + mBeat) : (mStart ^ mBeat);
    it.addr = {mHigh, low};
    it.wr   = gw ? 2'b11 : (bwe ? sel : 2'b00);
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare a quarter period after each rising edge.
  always @(posedge clk) begin
    #5;
    if (!finished && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      testsRun++;
      if (curAddr !== it.addr) begin
        testsFailed++;
        $display("FAIL %s curAddr actual=%h expected=%h", it.tag, curAddr, it.addr);
      end
      testsRun++;
      if (byteWrite !== it.wr) begin
        testsFailed++;
        $display("FAIL %s byteWrite actual=%b expected=%b", it.tag, byteWrite, it.wr);
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rstN = 1'b0;
    procStrobe = 0; ctrlStrobe = 0; advance = 0; linearOrder = 0;
    extAddr = '0; byteWrEn = 0; byteSel = 0; globalWr = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    testsRun++;
    if (curAddr !== '0 || byteWrite !== 2'b00) begin
      testsFailed++;
      $display("FAIL R1 actual=%h/%b expected=0/00", curAddr, byteWrite);
    end
    rstN = 1'b1;

    // R2, R5, R7: processor start, interleaved order, wrap past fourth beat
    drive(1, 0, 0, 0, 18'h2A5B6, 0, 2'b00, 0, "R2");
    for (int i = 0; i < 6; i++) drive(0, 0, 1, 0, 18'h00000, 0, 2'b00, 0, "R5_R7");
    // R4: hold without advance
    drive(0, 0, 0, 0, 18'h3FFFF, 0, 2'b00, 0, "R4");
    drive(0, 0, 0, 0, 18'h15555, 0, 2'b00, 0, "R4");

    // R2, R6, R7: controller start, linear order
    drive(0, 1, 0, 1, 18'h1C3F2, 0, 2'b00, 0, "R2");
    for (int i = 0; i < 6; i++) drive(0, 0, 1, 1, 18'h00001, 0, 2'b00, 0, "R6_R7");
    drive(0, 1, 0, 1, 18'h00003, 0, 2'b00, 0, "R6");
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 18'h0, 0, 2'b00, 0, "R6");

    // R3: both strobes with advance, then both strobes again
    drive(0, 0, 1, 0, 18'h0, 0, 2'b00, 0, "R4");
    drive(1, 1, 1, 0, 18'h3FFF1, 0, 2'b00, 0, "R3");
    drive(0, 0, 1, 0, 18'h0, 0, 2'b00, 0, "R3");
    drive(1, 1, 0, 0, 18'h0AAA2, 0, 2'b00, 0, "R3");
    drive(0, 0, 1, 0, 18'h0, 0, 2'b00, 0, "R5");

    // R8: per-lane writes; R10: writes do not move the address
    drive(0, 0, 0, 0, 18'h0, 1, 2'b01, 0, "R8_R10");
    drive(0, 0, 0, 0, 18'h0, 1, 2'b10, 0, "R8_R10");
    drive(0, 0, 0, 0, 18'h0, 1, 2'b11, 0, "R8_R10");
    drive(0, 0, 0, 0, 18'h0, 0, 2'b11, 0, "R8");
    drive(0, 0, 1, 0, 18'h0, 1, 2'b10, 0, "R8");
    // R9: global write regardless of lanes
    drive(0, 0, 0, 0, 18'h0, 0, 2'b00, 1, "R9_R10");
    drive(0, 0, 1, 0, 18'h0, 1, 2'b01, 1, "R9");
    drive(1, 0, 0, 1, 18'h20000, 0, 2'b10, 1, "R9");
    drive(0, 0, 0, 1, 18'h0, 0, 2'b00, 0, "R8");

    @(negedge clk); procStrobe = 0; ctrlStrobe = 0; advance = 0;
    byteWrEn = 0; globalWr = 0;
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule